// File: doc/BRIEF.md
# DRAM Bank Command Timing Gate

This block sits in front of the command path of a controller for a four-bank DDR2-style memory. It holds a small state machine and a set of down-counters for every bank, plus a few counters shared by all banks. From these it works out, every cycle, which commands the controller may legally issue to which bank: activate, read, write and precharge, and read or write with auto precharge. All spacing rules are supplied as clock-cycle counts on configuration inputs, together with CAS latency, additive latency, burst length and write recovery. The block therefore needs no knowledge of the clock period.

Commands enter through a valid/ready handshake. The requester places a command (kind, bank, auto-precharge flag) on the request pins with `cmd_valid` high, and the command is issued in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is derived only from the block's state and the request fields. It never depends on `cmd_valid`, so the requester may hold a request for as many cycles as the timing rules require, or withdraw it, without side effects. The per-bank `allow_*` vectors expose the same decisions for all kinds and banks at once, which lets a scheduler pick among several candidates. Two pulse outputs mark the cycle in which read data is due from the memory and the cycle in which write data must be presented to it.

Auto precharge is modelled inside the bank. After a read with auto precharge, the bank starts closing at the later of the read-to-precharge point and the minimum row-active point. After a write with auto precharge, the closing point lies write-recovery cycles past the end of the data burst. Until the bank has finished closing, it accepts no command.

Top module: `bank_cmd_gate`

## Requirements
- R1: After reset every bank is idle: `allow_act` and `allow_pre` are all ones, `allow_rd` and `allow_wr` are all zeros, and `rd_due`/`wr_due` are low.
- R2: Command kinds are encoded on `cmd_kind` as 0 = activate, 1 = read, 2 = write, 3 = precharge. `cmd_ready` equals the allow flag of the requested kind for `cmd_bank`. A command takes effect only in a cycle with `cmd_valid` and `cmd_ready` both high, and a request that is not accepted changes no state.
- R3: A read or write to a bank is allowed only while the bank is open and at least `t_rcd` cycles have passed since its activate.
- R4: An activate is refused while its bank is open. After a bank starts closing, whether by explicit or internal precharge, an activate to it is allowed `t_rp` cycles later.
- R5: An explicit precharge to an open bank is allowed only once three conditions hold. At least `t_ras` cycles have passed since the activate. At least AL + BL/2 − 2 + max(`t_rtp`, 2) cycles have passed since the last read to the bank. At least WL + BL/2 + `cfg_wr` cycles have passed since the last write to the bank.
- R6: A read with auto precharge makes the bank start closing at the later of the read-to-precharge point of R5 and the `t_ras` point. Until the bank has closed, it accepts no command.
- R7: A write with auto precharge makes the bank start closing WL + BL/2 + `cfg_wr` cycles after the write (or at the `t_ras` point, if that is later). Until then, it accepts no command.
- R8: Read latency is RL = `cfg_al` + `cfg_cl`, and write latency is WL = RL − 1. `rd_due` is high for one cycle exactly RL cycles after each read is issued, and `wr_due` exactly WL cycles after each write.
- R9: Two column commands (read or write) are always at least 2 cycles apart, which keeps every burst cut on a 4-beat boundary. A write after a read waits BL/2 + 2 cycles.
- R10: A read to any bank after a write waits WL + BL/2 + `t_wtr` cycles.
- R11: Two activates are at least `t_rrd` cycles apart.
- R12: At most four activates are issued in any `t_faw`-cycle window.
- R13: `cfg_bl8` high selects burst length 8 (BL/2 = 4), and low selects burst length 4 (BL/2 = 2). This value enters every BL/2 term above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl | input | CFGW | CAS latency in cycles (2 or more) |
| cfg_al | input | CFGW | Additive latency in cycles |
| cfg_bl8 | input | 1 | 1 = burst of 8, 0 = burst of 4 |
| cfg_wr | input | TW | Write recovery in cycles |
| t_rcd | input | TW | Activate to column command |
| t_ras | input | TW | Activate to precharge |
| t_rp | input | TW | Precharge to activate |
| t_rtp | input | TW | Read to precharge base value |
| t_wtr | input | TW | Write burst end to read |
| t_rrd | input | TW | Activate to activate, any banks |
| t_faw | input | TW | Four-activate window length |
| cmd_valid | input | 1 | Request present |
| cmd_kind | input | 2 | Command kind (R2 encoding) |
| cmd_bank | input | BW | Target bank |
| cmd_ap | input | 1 | Auto precharge with read/write |
| cmd_ready | output | 1 | Requested command may issue now |
| allow_act | output | NB | Per-bank activate allowed |
| allow_rd | output | NB | Per-bank read allowed |
| allow_wr | output | NB | Per-bank write allowed |
| allow_pre | output | NB | Per-bank precharge allowed |
| rd_due | output | 1 | Read data due this cycle |
| wr_due | output | 1 | Write data due this cycle |

## Verification
The hardest situation to reach from the ports is the one where two rules compete for the same event. This covers an auto precharge whose start is set by the row-active limit in one case and by the read-to-precharge limit in another. It also covers a fifth activate that has to be refused by the four-activate window, even though its own bank is already idle. The stimulus reaches these by changing the timing inputs between phases while banks are idle. It raises `t_ras` and `t_rtp` together with burst length 8, so that each limit wins once. It then shrinks `t_ras`, `t_rp` and `t_rrd` to one or two cycles, so that an activate, a precharge and three further activates fit inside a single window.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_AUTOPRE,
    BK_CLOSING
  } bank_st_e;
endpackage

// File: rtl/bcg_bank.sv
module bcg_bank
  import bcg_pkg::*;
#(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          pre_i,
  input  logic          ap_i,
  input  logic [GW-1:0] rcd_ld,
  input  logic [GW-1:0] ras_ld,
  input  logic [GW-1:0] rdpre_ld,
  input  logic [GW-1:0] wrpre_ld,
  input  logic [GW-1:0] rp_ld,
  output logic          can_act,
  output logic          can_col,
  output logic          can_pre
);
  bank_st_e      st_q;
  logic [GW-1:0] rcd_q, hold_q, rp_q;
  logic [GW-1:0] hold_dn, col_ld;

  function automatic logic [GW-1:0] dn(input logic [GW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign hold_dn = dn(hold_q);
  assign col_ld  = rd_i ? rdpre_ld : wrpre_ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= BK_IDLE;
      rcd_q  <= '0;
      hold_q <= '0;
      rp_q   <= '0;
    end else begin
      rcd_q  <= dn(rcd_q);
      hold_q <= hold_dn;
      rp_q   <= dn(rp_q);
      unique case (st_q)
        BK_IDLE: begin
          if (act_i) begin
            st_q   <= BK_OPEN;
            rcd_q  <= rcd_ld;
            hold_q <= ras_ld;
          end
        end
        BK_OPEN: begin
          if (rd_i || wr_i) begin
            hold_q <= (col_ld > hold_dn) ? col_ld : hold_dn;
            if (ap_i) st_q <= BK_AUTOPRE;
          end else if (pre_i) begin
            st_q <= BK_CLOSING;
            rp_q <= rp_ld;
          end
        end
        BK_AUTOPRE: begin
          if (hold_q == '0) begin
            st_q <= BK_CLOSING;
            rp_q <= rp_ld;
          end
        end
        BK_CLOSING: begin
          if (act_i) begin
            st_q   <= BK_OPEN;
            rcd_q  <= rcd_ld;
            hold_q <= ras_ld;
          end else if (rp_q == '0) begin
            st_q <= BK_IDLE;
          end
        end
        default: st_q <= BK_IDLE;
      endcase
    end
  end

  assign can_act = (st_q == BK_IDLE) || ((st_q == BK_CLOSING) && (rp_q == '0));
  assign can_col = (st_q == BK_OPEN) && (rcd_q == '0);
  assign can_pre = (st_q == BK_IDLE) || ((st_q == BK_OPEN) && (hold_q == '0));
endmodule

// File: rtl/bcg_shared.sv
module bcg_shared #(
  parameter int TW      = 6,
  parameter int GW      = 8,
  parameter int ACT_WIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [TW-1:0] rrd_ld,
  input  logic [TW-1:0] faw_ld,
  input  logic [GW-1:0] rd2wr_ld,
  input  logic [GW-1:0] wr2rd_ld,
  output logic          act_ok,
  output logic          rd_ok,
  output logic          wr_ok
);
  logic [TW-1:0]      rrd_q;
  logic [GW-1:0]      rd2wr_q, wr2rd_q;
  logic               ccd_q;
  logic [ACT_WIN-1:0] busy, slot_sel;

  always_comb begin
    slot_sel = '0;
    for (int i = 0; i < ACT_WIN; i++) begin
      if (!busy[i] && (slot_sel == '0)) slot_sel[i] = 1'b1;
    end
  end

  for (genvar i = 0; i < ACT_WIN; i++) begin : g_win
    logic [TW-1:0] win_q;
    assign busy[i] = (win_q != '0);
    always_ff @(posedge clk) begin
      if (!rst_n)                    win_q <= '0;
      else if (act_i && slot_sel[i]) win_q <= faw_ld;
      else if (win_q != '0)          win_q <= win_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q   <= '0;
      rd2wr_q <= '0;
      wr2rd_q <= '0;
      ccd_q   <= 1'b0;
    end else begin
      ccd_q <= rd_i || wr_i;
      if (act_i)              rrd_q <= rrd_ld;
      else if (rrd_q != '0)   rrd_q <= rrd_q - 1'b1;
      if (rd_i)               rd2wr_q <= rd2wr_ld;
      else if (rd2wr_q != '0) rd2wr_q <= rd2wr_q - 1'b1;
      if (wr_i)               wr2rd_q <= wr2rd_ld;
      else if (wr2rd_q != '0) wr2rd_q <= wr2rd_q - 1'b1;
    end
  end

  assign act_ok = (rrd_q == '0) && (busy != '1);
  assign rd_ok  = !ccd_q && (wr2rd_q == '0);
  assign wr_ok  = !ccd_q && (rd2wr_q == '0);
endmodule

// File: rtl/bcg_due.sv
module bcg_due #(
  parameter int LW = 4,
  parameter int LD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [LW-1:0] rl,
  input  logic [LW-1:0] wl,
  output logic          rd_due,
  output logic          wr_due
);
  logic [LD-1:0] rd_pipe, wr_pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pipe <= '0;
      wr_pipe <= '0;
    end else begin
      rd_pipe <= (rd_pipe >> 1) | (rd_i ? (LD'(1) << (rl - 1'b1)) : '0);
      wr_pipe <= (wr_pipe >> 1) | (wr_i ? (LD'(1) << (wl - 1'b1)) : '0);
    end
  end

  assign rd_due = rd_pipe[0];
  assign wr_due = wr_pipe[0];
endmodule

// File: rtl/bank_cmd_gate.sv
module bank_cmd_gate
  import bcg_pkg::*;
#(
  parameter int NB   = 4,
  parameter int TW   = 6,
  parameter int CFGW = 3,
  parameter int BW   = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CFGW-1:0] cfg_cl,
  input  logic [CFGW-1:0] cfg_al,
  input  logic            cfg_bl8,
  input  logic [TW-1:0]   cfg_wr,
  input  logic [TW-1:0]   t_rcd,
  input  logic [TW-1:0]   t_ras,
  input  logic [TW-1:0]   t_rp,
  input  logic [TW-1:0]   t_rtp,
  input  logic [TW-1:0]   t_wtr,
  input  logic [TW-1:0]   t_rrd,
  input  logic [TW-1:0]   t_faw,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_kind,
  input  logic [BW-1:0]   cmd_bank,
  input  logic            cmd_ap,
  output logic            cmd_ready,
  output logic [NB-1:0]   allow_act,
  output logic [NB-1:0]   allow_rd,
  output logic [NB-1:0]   allow_wr,
  output logic [NB-1:0]   allow_pre,
  output logic            rd_due,
  output logic            wr_due
);
  localparam int GW = TW + 2;
  localparam int LW = CFGW + 1;
  localparam int LD = 2 ** LW;

  function automatic logic [GW-1:0] m1(input logic [GW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [LW-1:0] rl, wl;
  logic [GW-1:0] half, rtp_eff, rdpre_gap, wrpre_gap, wr2rd_gap, rd2wr_gap;
  logic [GW-1:0] rcd_ld, ras_ld, rp_ld, rrd_w, faw_w;
  logic          iss, iss_act, iss_rd, iss_wr, iss_pre;
  logic [NB-1:0] bk_act, bk_col, bk_pre;
  logic          g_act, g_rd, g_wr;

  assign rl        = LW'(cfg_al) + LW'(cfg_cl);
  assign wl        = rl - 1'b1;
  assign half      = cfg_bl8 ? GW'(4) : GW'(2);
  assign rtp_eff   = (t_rtp < TW'(2)) ? GW'(2) : GW'(t_rtp);
  assign rdpre_gap = GW'(cfg_al) + half - GW'(2) + rtp_eff;
  assign wrpre_gap = GW'(wl) + half + GW'(cfg_wr);
  assign wr2rd_gap = GW'(wl) + half + GW'(t_wtr);
  assign rd2wr_gap = half + GW'(2);
  assign rcd_ld    = m1(GW'(t_rcd));
  assign ras_ld    = m1(GW'(t_ras));
  assign rp_ld     = m1(GW'(t_rp));
  assign rrd_w     = m1(GW'(t_rrd));
  assign faw_w     = m1(GW'(t_faw));

  always_comb begin
    unique case (cmd_e'(cmd_kind))
      CMD_ACT: cmd_ready = allow_act[cmd_bank];
      CMD_RD:  cmd_ready = allow_rd[cmd_bank];
      CMD_WR:  cmd_ready = allow_wr[cmd_bank];
      default: cmd_ready = allow_pre[cmd_bank];
    endcase
  end

  assign iss     = cmd_valid && cmd_ready;
  assign iss_act = iss && (cmd_e'(cmd_kind) == CMD_ACT);
  assign iss_rd  = iss && (cmd_e'(cmd_kind) == CMD_RD);
  assign iss_wr  = iss && (cmd_e'(cmd_kind) == CMD_WR);
  assign iss_pre = iss && (cmd_e'(cmd_kind) == CMD_PRE);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BW'(b));
    bcg_bank #(.GW(GW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (iss_act && hit),
      .rd_i     (iss_rd && hit),
      .wr_i     (iss_wr && hit),
      .pre_i    (iss_pre && hit),
      .ap_i     (cmd_ap),
      .rcd_ld   (rcd_ld),
      .ras_ld   (ras_ld),
      .rdpre_ld (m1(rdpre_gap)),
      .wrpre_ld (m1(wrpre_gap)),
      .rp_ld    (rp_ld),
      .can_act  (bk_act[b]),
      .can_col  (bk_col[b]),
      .can_pre  (bk_pre[b])
    );
    assign allow_act[b] = bk_act[b] && g_act;
    assign allow_rd[b]  = bk_col[b] && g_rd;
    assign allow_wr[b]  = bk_col[b] && g_wr;
    assign allow_pre[b] = bk_pre[b];
  end

  bcg_shared #(.TW(TW), .GW(GW), .ACT_WIN(4)) u_shared (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (iss_act),
    .rd_i     (iss_rd),
    .wr_i     (iss_wr),
    .rrd_ld   (rrd_w[TW-1:0]),
    .faw_ld   (faw_w[TW-1:0]),
    .rd2wr_ld (m1(rd2wr_gap)),
    .wr2rd_ld (m1(wr2rd_gap)),
    .act_ok   (g_act),
    .rd_ok    (g_rd),
    .wr_ok    (g_wr)
  );

  bcg_due #(.LW(LW), .LD(LD)) u_due (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_i   (iss_rd),
    .wr_i   (iss_wr),
    .rl     (rl),
    .wl     (wl),
    .rd_due (rd_due),
    .wr_due (wr_due)
  );
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int NB = 4,
  parameter int TW = 6,
  parameter int BW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] t_rcd,
  input logic [TW-1:0] t_ras,
  input logic [TW-1:0] t_rrd,
  input logic          cmd_valid,
  input logic [1:0]    cmd_kind,
  input logic [BW-1:0] cmd_bank,
  input logic          cmd_ready,
  input logic [NB-1:0] allow_act,
  input logic [NB-1:0] allow_rd,
  input logic [NB-1:0] allow_wr,
  input logic [NB-1:0] allow_pre
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_RCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_kind == 2'd0 && t_rcd >= TW'(2)) |=> !allow_rd[$past(cmd_bank)]); // R3
  AST_OPEN_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_kind == 2'd0) |=> !allow_act[$past(cmd_bank)]); // R4
  AST_RAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_kind == 2'd0 && t_ras >= TW'(2)) |=> !allow_pre[$past(cmd_bank)]); // R5
  AST_COL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_kind == 2'd1 || cmd_kind == 2'd2)) |=> (allow_rd == '0 && allow_wr == '0)); // R9
  AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_kind == 2'd0 && t_rrd >= TW'(2)) |=> (allow_act == '0)); // R11
  AST_COL_ACT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (((allow_rd | allow_wr) & allow_act) == '0)); // R3
endmodule

bind bank_cmd_gate bcg_checker #(.NB(NB), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .t_rcd     (t_rcd),
  .t_ras     (t_ras),
  .t_rrd     (t_rrd),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .cmd_bank  (cmd_bank),
  .cmd_ready (cmd_ready),
  .allow_act (allow_act),
  .allow_rd  (allow_rd),
  .allow_wr  (allow_wr),
  .allow_pre (allow_pre)
);

// File: tb/bank_cmd_gate_tb.sv
module bank_cmd_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_ACT = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_PRE = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cfg_cl, cfg_al;
  logic cfg_bl8;
  logic [5:0] cfg_wr, t_rcd, t_ras, t_rp, t_rtp, t_wtr, t_rrd, t_faw;
  logic cmd_valid, cmd_ap, cmd_ready, rd_due, wr_due;
  logic [1:0] cmd_kind, cmd_bank;
  logic [3:0] allow_act, allow_rd, allow_wr, allow_pre;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  int rdq[$];
  int wrq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bank_cmd_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
    .cfg_wr(cfg_wr), .t_rcd(t_rcd), .t_ras(t_ras), .t_rp(t_rp), .t_rtp(t_rtp),
    .t_wtr(t_wtr), .t_rrd(t_rrd), .t_faw(t_faw), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_ready(cmd_ready),
    .allow_act(allow_act), .allow_rd(allow_rd), .allow_wr(allow_wr),
    .allow_pre(allow_pre), .rd_due(rd_due), .wr_due(wr_due)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic goto(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] k, input int b, input logic ap, input string tag);
    int rl;
    rl = int'(cfg_al) + int'(cfg_cl);
    cmd_valid = 1'b1; cmd_kind = k; cmd_bank = b[1:0]; cmd_ap = ap;
    #1;
    chk(tag, cmd_ready, 1);
    if (k == K_RD) rdq.push_back(cyc + rl);
    if (k == K_WR) wrq.push_back(cyc + rl - 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // scoreboard monitor for R8: data-due pulses against the queued cycles
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit er, ew;
      er = (rdq.size() > 0) && (rdq[0] == cyc);
      ew = (wrq.size() > 0) && (wrq[0] == cyc);
      if (er || rd_due) begin
        chk("R8 rd_due", rd_due, er);
        if (er) void'(rdq.pop_front());
      end
      if (ew || wr_due) begin
        chk("R8 wr_due", wr_due, ew);
        if (ew) void'(wrq.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = K_ACT; cmd_bank = 2'd0; cmd_ap = 1'b0;
    cfg_cl = 3'd3; cfg_al = 3'd1; cfg_bl8 = 1'b0; cfg_wr = 6'd3;
    t_rcd = 6'd3; t_ras = 6'd8; t_rp = 6'd3; t_rtp = 6'd2; t_wtr = 6'd2;
    t_rrd = 6'd2; t_faw = 6'd10;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 allow_act", allow_act, 4'hF);
    chk("R1 allow_pre", allow_pre, 4'hF);
    chk("R1 allow_rd", allow_rd, 0);
    chk("R1 allow_wr", allow_wr, 0);
    chk("R1 due", {rd_due, wr_due}, 0);

    goto(10); send(K_ACT, 0, 1'b0, "R3 act b0");
    chk("R3 rd b0 early", allow_rd[0], 0);
    chk("R11 act b1 rrd", allow_act[1], 0);
    chk("R4 act open b0", allow_act[0], 0);
    cmd_valid = 1'b1; cmd_kind = K_ACT; cmd_bank = 2'd1; #1;
    chk("R2 ready low", cmd_ready, 0);
    @(negedge clk); cmd_valid = 1'b0;
    chk("R2 not taken", allow_act[1], 1);
    chk("R3 rd b0 c12", allow_rd[0], 0);
    goto(13); chk("R3 rd b0 c13", allow_rd[0], 1);
    send(K_RD, 0, 1'b0, "R3 rd b0");
    chk("R9 rd spacing", allow_rd[0], 0);
    chk("R9 wr spacing", allow_wr[0], 0);
    goto(15); chk("R9 rd after 2", allow_rd[0], 1);
    goto(16); chk("R9 rd2wr c16", allow_wr[0], 0);
    goto(17); chk("R9 rd2wr c17", allow_wr[0], 1);
    chk("R5 ras c17", allow_pre[0], 0);
    goto(18); chk("R5 ras c18", allow_pre[0], 1);
    send(K_PRE, 0, 1'b0, "R5 pre b0");
    goto(20); chk("R4 rp c20", allow_act[0], 0);
    goto(21); chk("R4 rp c21", allow_act[0], 1);
    send(K_ACT, 1, 1'b0, "R4 act b1");
    goto(23); send(K_ACT, 2, 1'b0, "R11 act b2");
    send(K_WR, 1, 1'b1, "R7 wr ap b1");
    goto(26); chk("R7 rd blocked", allow_rd[1], 0);
    chk("R7 pre blocked", allow_pre[1], 0);
    goto(30); chk("R10 wtr c30", allow_rd[2], 0);
    goto(31); chk("R10 wtr c31", allow_rd[2], 1);
    send(K_RD, 2, 1'b1, "R6 rd ap b2");
    goto(34); chk("R7 ap c34", allow_act[1], 0);
    goto(35); chk("R7 ap c35", allow_act[1], 1);
    goto(36); chk("R6 ap c36", allow_act[2], 0);
    goto(37); chk("R6 ap c37", allow_act[2], 1);

    goto(40); cfg_bl8 = 1'b1; t_rtp = 6'd4; t_ras = 6'd14;
    goto(41); send(K_ACT, 3, 1'b0, "R6 act b3");
    goto(43); send(K_ACT, 0, 1'b0, "R13 act b0");
    send(K_RD, 3, 1'b1, "R6 rd ap b3");
    goto(52); send(K_RD, 0, 1'b1, "R13 rd ap b0");
    goto(57); chk("R6 ras wins c57", allow_act[3], 0);
    goto(58); chk("R6 ras wins c58", allow_act[3], 1);
    goto(61); chk("R13 bl8 gap c61", allow_act[0], 0);
    goto(62); chk("R13 bl8 gap c62", allow_act[0], 1);

    goto(65); t_ras = 6'd2; t_rp = 6'd1; t_rrd = 6'd1;
    goto(66); send(K_ACT, 0, 1'b0, "R12 act b0");
    goto(68); send(K_PRE, 0, 1'b0, "R5 pre short");
    send(K_ACT, 1, 1'b0, "R12 act b1");
    send(K_ACT, 2, 1'b0, "R12 act b2");
    send(K_ACT, 3, 1'b0, "R12 act b3");
    chk("R12 window c72", allow_act[0], 0);
    goto(75); chk("R12 window c75", allow_act[0], 0);
    goto(76); chk("R12 window c76", allow_act[0], 1);

    goto(80);
    chk("R8 queues drained", rdq.size() + wrq.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule